// File: doc/BRIEF.md
# Six-Source Four-Level Interrupt Arbiter

This block sits beside a small microcontroller core and decides which of six interrupt sources gets serviced next. There are two external request pins, three timers and a serial port. Software programs an enable register, with one global enable bit and one bit per source, and two priority registers. One bit from each priority register, taken together, places every source on one of four levels. Among the sources that are both pending and enabled, the arbiter picks the one on the highest level. When several sit on that level, a fixed polling order breaks the tie.

The arbiter raises a request line toward the core and presents the vector address of the winning source. It keeps a four-bit record of the levels currently in service. A new request reaches the core only when its level is strictly above every level already in service, which lets handlers nest. The core reports each grant on an acknowledge strobe and each handler exit on a return strobe. On acknowledge, the arbiter emits one-cycle clear pulses for the two timer overflow flags. It clears its own edge-latched external flags itself. The serial and timer-2 flags are left for software to clear.

Top module: `irq_arb6`

## Requirements
- R1: The enable register is written at address A8h: bit 7 is the global enable, and bits 0..5 enable the sources in polling order. The low priority register is written at B8h and the high priority register at B7h, with bits 0..5 in the same source order. A write to any other address changes nothing.
- R2: A source is pending only when its flag is set, its enable bit is 1 and the global enable bit is 1. With no pending source, `irq` is 0.
- R3: The level of source n is the two-bit value {high[n], low[n]}, where 3 is the highest. The pending source on the highest level wins.
- R4: Among pending sources on the same level, the winner is the first one in the order ext0, timer0, ext1, timer1, serial, timer2. These are source indices 0 to 5.
- R5: `vector` equals 03h + 8 × index of the winner, giving 03h, 0Bh, 13h, 1Bh, 23h or 2Bh.
- R6: The serial request is `ser_ri` OR `ser_ti`, and the timer-2 request is `tf2` OR `exf2`. Acknowledging either of these produces no clear pulse, so the request persists while its inputs stay high.
- R7: An acknowledge that grants timer0 (or timer1) drives `clr_tf0` (or `clr_tf1`) high for exactly the one cycle after the acknowledge edge. The other pulse stays low.
- R8: With its mode bit 0 (level mode), an external flag equals the inverted pin as sampled at the previous clock edge. It is not cleared by acknowledge.
- R9: With its mode bit 1 (edge mode), a high-to-low pin transition sets the external flag. The flag stays set after the pin returns high, and it is cleared when that source is acknowledged.
- R10: `irq` is 1 only if the winner's level is strictly greater than every level in service. An acknowledge while `irq` is 1 marks the winner's level as in service.
- R11: A `reti` strobe removes only the highest level in service.
- R12: After reset all three registers are zero, no level is in service, `irq` is 0 and both clear pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext0_n | input | 1 | External request pin 0, active low |
| ext1_n | input | 1 | External request pin 1, active low |
| ext_edge | input | 2 | Per-pin mode: 1 edge, 0 level (bit 0 for ext0) |
| tf0 | input | 1 | Timer 0 overflow flag |
| tf1 | input | 1 | Timer 1 overflow flag |
| ser_ri | input | 1 | Serial receive flag |
| ser_ti | input | 1 | Serial transmit flag |
| tf2 | input | 1 | Timer 2 overflow flag |
| exf2 | input | 1 | Timer 2 external flag |
| ack | input | 1 | Core accepts the current request |
| reti | input | 1 | Core leaves the current handler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| irq | output | 1 | Interrupt request to the core |
| vector | output | 8 | Vector address of the winner |
| clr_tf0 | output | 1 | Hardware clear pulse for timer 0 flag |
| clr_tf1 | output | 1 | Hardware clear pulse for timer 1 flag |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:

- **Same-level ties.** A design with the polling order reversed would vector to 2Bh instead of 23h or 0Bh.
- **Level formation.** A design that swaps the high and low priority bits would let the wrong timer win.
- **Nesting.** A request on the same level as the handler in service must stay masked. A comparison of "greater or equal" would raise `irq` too early. A return strobe must release only the top level, so clearing the whole in-service mask would re-admit a masked request one handler too soon.
- **Flag clearing.** Level-mode and edge-mode external flags must be cleared differently on acknowledge. Timer clear pulses must be single-cycle and go only to the granted timer, and the serial and timer-2 requests must never receive one.

// File: rtl/irq_arb6_pkg.sv
// Shared constants for the six-source interrupt arbiter.
// Assumes source indices follow the fixed polling order, index 0 polled first.
package irq_arb6_pkg;
    localparam int NSRC   = 6;
    localparam int LVLW   = 2;
    localparam int NLVL   = 1 << LVLW;
    localparam int IDXW   = $clog2(NSRC);
    localparam int NEXT   = 2;
    localparam int AW     = 8;
    localparam int DW     = 8;
    localparam logic [AW-1:0] ADDR_EN  = 8'hA8;
    localparam logic [AW-1:0] ADDR_PLO = 8'hB8;
    localparam logic [AW-1:0] ADDR_PHI = 8'hB7;
    localparam logic [7:0]    VEC_BASE = 8'h03;
    localparam int            VEC_SHIFT = 3;

    typedef enum logic [IDXW-1:0] {
        SRC_X0 = 3'd0,
        SRC_T0 = 3'd1,
        SRC_X1 = 3'd2,
        SRC_T1 = 3'd3,
        SRC_SP = 3'd4,
        SRC_T2 = 3'd5
    } src_e;
endpackage

// File: rtl/irq_ext_capture.sv
// External request capture for one active-low pin.
// Level mode: the flag mirrors the inverted pin one cycle late.
// Edge mode: a falling edge sets the flag, and an acknowledge of this source
// clears it. A new edge wins over a clear in the same cycle.
// Assumes the pin is already synchronous to clk.
module irq_ext_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic flag
);
    logic pin_q;
    logic fall;

    // Hold the previous pin sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= pin_n;
    end

    assign fall = pin_q & ~pin_n;

    // Update the request flag according to the selected mode.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag <= 1'b0;
        else if (!edge_mode) flag <= ~pin_n;
        else if (fall)       flag <= 1'b1;
        else if (clr)        flag <= 1'b0;
    end
endmodule

// File: rtl/irq_prio_select.sv
// Combinational winner search over the pending sources.
// The highest level wins. Because replacement requires a strictly greater
// level, the lowest index is kept on ties.
module irq_prio_select #(
    parameter int NSRC = 6,
    parameter int LVLW = 2,
    localparam int IDXW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] lvl_hi,
    input  logic [NSRC-1:0] lvl_lo,
    output logic            found,
    output logic [IDXW-1:0] win_idx,
    output logic [LVLW-1:0] win_lvl
);
    // Scan in polling order and keep the best candidate seen so far.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && (!found || {lvl_hi[i], lvl_lo[i]} > win_lvl)) begin
                found   = 1'b1;
                win_idx = IDXW'(i);
                win_lvl = {lvl_hi[i], lvl_lo[i]};
            end
        end
    end
endmodule

// File: rtl/irq_level_stack.sv
// In-service level mask.
// A grant sets the granted level's bit, and a return clears the highest set
// bit. A candidate may preempt only if no bit at or above its level is set.
// Assumes the core never returns with an empty mask.
module irq_level_stack #(
    parameter int LVLW = 2,
    localparam int NLVL = 1 << LVLW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            grant,
    input  logic [LVLW-1:0] grant_lvl,
    input  logic            reti,
    input  logic [LVLW-1:0] cand_lvl,
    output logic            may_preempt,
    output logic [NLVL-1:0] isv
);
    logic [NLVL-1:0] top_bit;
    logic [NLVL-1:0] isv_nx;
    logic            seen;

    // Locate the highest level in service.
    always_comb begin
        top_bit = '0;
        seen    = 1'b0;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (!seen && isv[i]) begin
                top_bit[i] = 1'b1;
                seen       = 1'b1;
            end
        end
    end

    // Form the next mask: apply the return first, then the grant.
    always_comb begin
        isv_nx = reti ? (isv & ~top_bit) : isv;
        if (grant) isv_nx[grant_lvl] = 1'b1;
    end

    // Register the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) isv <= '0;
        else        isv <= isv_nx;
    end

    assign may_preempt = (isv >> cand_lvl) == '0;
endmodule

// File: rtl/irq_arb6.sv
// Six-source four-level interrupt arbiter, top level.
// Holds the enable and both priority registers and forms the per-source
// requests. It drives irq and vector combinationally, and emits registered
// one-cycle timer clear pulses. Assumes ack is only meaningful while irq is
// high, and that the core reads vector in the cycle it asserts ack.
module irq_arb6
    import irq_arb6_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext0_n,
    input  logic          ext1_n,
    input  logic [1:0]    ext_edge,
    input  logic          tf0,
    input  logic          tf1,
    input  logic          ser_ri,
    input  logic          ser_ti,
    input  logic          tf2,
    input  logic          exf2,
    input  logic          ack,
    input  logic          reti,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          irq,
    output logic [7:0]    vector,
    output logic          clr_tf0,
    output logic          clr_tf1
);
    logic            ea_q;
    logic [NSRC-1:0] en_q, plo_q, phi_q;
    logic [NEXT-1:0] ext_pin_n, ext_flag, ext_clr;
    logic [NSRC-1:0] req, pend;
    logic            found, may_preempt, grant;
    logic [IDXW-1:0] win_idx;
    logic [LVLW-1:0] win_lvl;
    logic [NLVL-1:0] isv;
    logic            unused_wr_bits;

    assign unused_wr_bits = ^wr_data[DW-2:NSRC];

    // Register write port for the enable and both priority registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q  <= 1'b0;
            en_q  <= '0;
            plo_q <= '0;
            phi_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_EN) begin
                ea_q <= wr_data[DW-1];
                en_q <= wr_data[NSRC-1:0];
            end
            if (wr_addr == ADDR_PLO) plo_q <= wr_data[NSRC-1:0];
            if (wr_addr == ADDR_PHI) phi_q <= wr_data[NSRC-1:0];
        end
    end

    assign ext_pin_n = {ext1_n, ext0_n};
    assign ext_clr[0] = grant && (win_idx == IDXW'(SRC_X0));
    assign ext_clr[1] = grant && (win_idx == IDXW'(SRC_X1));

    generate
        for (genvar g = 0; g < NEXT; g++) begin : g_ext
            irq_ext_capture u_cap (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_n    (ext_pin_n[g]),
                .edge_mode(ext_edge[g]),
                .clr      (ext_clr[g]),
                .flag     (ext_flag[g])
            );
        end
    endgenerate

    assign req  = {tf2 | exf2, ser_ri | ser_ti, tf1, ext_flag[1], tf0, ext_flag[0]};
    assign pend = req & en_q & {NSRC{ea_q}};

    irq_prio_select #(.NSRC(NSRC), .LVLW(LVLW)) u_sel (
        .pend   (pend),
        .lvl_hi (phi_q),
        .lvl_lo (plo_q),
        .found  (found),
        .win_idx(win_idx),
        .win_lvl(win_lvl)
    );

    irq_level_stack #(.LVLW(LVLW)) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant      (grant),
        .grant_lvl  (win_lvl),
        .reti       (reti),
        .cand_lvl   (win_lvl),
        .may_preempt(may_preempt),
        .isv        (isv)
    );

    assign irq    = found && may_preempt;
    assign grant  = ack && irq;
    assign vector = VEC_BASE + (8'(win_idx) << VEC_SHIFT);

    // Hardware clear pulses for the timer flags, one cycle after the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_tf0 <= 1'b0;
            clr_tf1 <= 1'b0;
        end else begin
            clr_tf0 <= grant && (win_idx == IDXW'(SRC_T0));
            clr_tf1 <= grant && (win_idx == IDXW'(SRC_T1));
        end
    end
endmodule

// File: rtl/irq_arb6_chk.sv
// Property checker for irq_arb6, attached with bind.
// Observes the ports plus the global enable and the in-service mask.
module irq_arb6_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic [7:0] vector,
    input logic       ack,
    input logic       reti,
    input logic       clr_tf0,
    input logic       clr_tf1,
    input logic       ea,
    input logic [3:0] isv
);
    AST_CLR0_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        clr_tf0 |-> $past(ack)); // R7
    AST_CLR1_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        clr_tf1 |-> $past(ack)); // R7
    AST_CLR0_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_tf0 |=> !clr_tf0); // R7
    AST_CLR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_tf0 && clr_tf1)); // R7
    AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vector[2:0] == 3'b011 && vector <= 8'h2B)); // R5
    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ea |-> !irq); // R2
    AST_TOP_LEVEL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        isv[3] |-> !irq); // R10
    AST_RETI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !ack && isv != 4'b0) |=> $countones(isv) == $countones($past(isv)) - 1); // R11
endmodule

bind irq_arb6 irq_arb6_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq    (irq),
    .vector (vector),
    .ack    (ack),
    .reti   (reti),
    .clr_tf0(clr_tf0),
    .clr_tf1(clr_tf1),
    .ea     (ea_q),
    .isv    (isv)
);

// File: tb/irq_arb6_bench.sv
// Self-checking bench for irq_arb6: a vector table followed by directed tests.
module irq_arb6_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext0_n = 1'b1, ext1_n = 1'b1;
    logic [1:0] ext_edge = 2'b00;
    logic       tf0 = 0, tf1 = 0, ser_ri = 0, ser_ti = 0, tf2 = 0, exf2 = 0;
    logic       ack = 0, reti = 0, wr_en = 0;
    logic [7:0] wr_addr = 0, wr_data = 0;
    logic       irq, clr_tf0, clr_tf1;
    logic [7:0] vector;
    int         total = 0, bad = 0;

    always #10 clk = ~clk;

    irq_arb6 u_irq_arb6 (.*);

    // Entry: {enable, prio_lo, prio_hi, flags{exf2,tf2,ti,ri,tf1,tf0}, irq, vector}
    localparam int NVEC = 11;
    localparam logic [38:0] VEC_TBL [NVEC] = '{
        {8'h02, 8'h00, 8'h00, 6'b000001, 1'b0, 8'h00},
        {8'h82, 8'h00, 8'h00, 6'b000001, 1'b1, 8'h0B},
        {8'hBF, 8'h00, 8'h00, 6'b010111, 1'b1, 8'h0B},
        {8'hBF, 8'h20, 8'h00, 6'b010111, 1'b1, 8'h2B},
        {8'hBF, 8'h20, 8'h08, 6'b010111, 1'b1, 8'h1B},
        {8'hBF, 8'h08, 8'h0A, 6'b010111, 1'b1, 8'h1B},
        {8'h90, 8'h00, 8'h00, 6'b001000, 1'b1, 8'h23},
        {8'hA0, 8'h00, 8'h00, 6'b100000, 1'b1, 8'h2B},
        {8'h9F, 8'h00, 8'h00, 6'b100000, 1'b0, 8'h00},
        {8'hBF, 8'h00, 8'h30, 6'b010100, 1'b1, 8'h23},
        {8'h00, 8'h3F, 8'h3F, 6'b111111, 1'b0, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic strobe_ack();
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0;
    endtask

    task automatic strobe_reti();
        @(negedge clk); reti = 1;
        @(negedge clk); reti = 0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R12 irq after reset", 8'(irq), 8'h0);
        chk("R12 clr_tf0 after reset", 8'(clr_tf0), 8'h0);
        chk("R12 clr_tf1 after reset", 8'(clr_tf1), 8'h0);
        tf0 = 1; wr(8'hA8, 8'h00); #1;
        chk("R12 enable register zero", 8'(irq), 8'h0);
        tf0 = 0;

        // Table walk: R1 R2 R3 R4 R5 R6
        for (int k = 0; k < NVEC; k++) begin
            {exf2, tf2, ser_ti, ser_ri, tf1, tf0} = VEC_TBL[k][14:9];
            wr(8'hA8, VEC_TBL[k][38:31]);
            wr(8'hB8, VEC_TBL[k][30:23]);
            wr(8'hB7, VEC_TBL[k][22:15]);
            #1;
            chk("R1 R2 R3 R4 R6 table irq", 8'(irq), 8'(VEC_TBL[k][8]));
            if (VEC_TBL[k][8]) chk("R3 R4 R5 table vector", vector, VEC_TBL[k][7:0]);
        end

        // R1: writes to other addresses leave the registers alone.
        {exf2, tf2, ser_ti, ser_ri, tf1, tf0} = 6'b000001;
        wr(8'hB8, 8'h00); wr(8'hB7, 8'h00); wr(8'hA8, 8'h82);
        wr(8'hA9, 8'h00); wr(8'hB9, 8'h00); wr(8'hB6, 8'hFF);
        #1;
        chk("R1 stray write irq", 8'(irq), 8'h1);
        chk("R1 stray write vector", vector, 8'h0B);
        tf0 = 0;

        // R8: level-mode external 0.
        ext_edge = 2'b00;
        wr(8'hA8, 8'h81);
        ext0_n = 0; #1;
        chk("R8 one cycle latency", 8'(irq), 8'h0);
        @(negedge clk); #1;
        chk("R8 level request irq", 8'(irq), 8'h1);
        chk("R8 R5 level request vector", vector, 8'h03);
        strobe_ack(); #1;
        chk("R10 same level masked after ack", 8'(irq), 8'h0);
        strobe_reti(); #1;
        chk("R8 level flag not cleared by ack", 8'(irq), 8'h1);
        ext0_n = 1;
        @(negedge clk); #1;
        chk("R8 flag follows pin high", 8'(irq), 8'h0);

        // R9: edge-mode external 1.
        ext_edge = 2'b10;
        wr(8'hA8, 8'h84);
        ext1_n = 0;
        @(negedge clk); #1;
        chk("R9 falling edge latched", 8'(irq), 8'h1);
        chk("R9 R5 edge vector", vector, 8'h13);
        ext1_n = 1;
        @(negedge clk); #1;
        chk("R9 flag held after pin rises", 8'(irq), 8'h1);
        strobe_ack();
        strobe_reti(); #1;
        chk("R9 flag cleared by ack", 8'(irq), 8'h0);
        ext_edge = 2'b00;

        // R10 R11 R7 R6: nesting and clear pulses.
        wr(8'hA8, 8'hAA); wr(8'hB8, 8'h08); wr(8'hB7, 8'h00);
        tf0 = 1; #1;
        chk("R10 idle grants level 0", 8'(irq), 8'h1);
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0; tf0 = 0; #1;
        chk("R7 clr_tf0 pulse", 8'(clr_tf0), 8'h1);
        chk("R7 clr_tf1 quiet", 8'(clr_tf1), 8'h0);
        tf2 = 1;
        @(negedge clk); #1;
        chk("R7 clr_tf0 one cycle", 8'(clr_tf0), 8'h0);
        chk("R10 equal level blocked", 8'(irq), 8'h0);
        tf1 = 1; #1;
        chk("R10 higher level preempts", 8'(irq), 8'h1);
        chk("R10 R5 preempt vector", vector, 8'h1B);
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0; tf1 = 0; #1;
        chk("R7 clr_tf1 pulse", 8'(clr_tf1), 8'h1);
        chk("R10 nested masks level 0", 8'(irq), 8'h0);
        strobe_reti(); #1;
        chk("R11 reti drops only top level", 8'(irq), 8'h0);
        strobe_reti(); #1;
        chk("R11 second reti releases", 8'(irq), 8'h1);
        chk("R11 R5 released vector", vector, 8'h2B);
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0; #1;
        chk("R6 no clr_tf0 for timer2", 8'(clr_tf0), 8'h0);
        chk("R6 no clr_tf1 for timer2", 8'(clr_tf1), 8'h0);
        strobe_reti(); #1;
        chk("R6 timer2 request persists", 8'(irq), 8'h1);
        tf2 = 0;

        finish_run();
    end
endmodule